// File: doc/BRIEF.md
# Serial-Loaded Work-RAM Bank Selector

This block sits on the cartridge side of an 8-bit CPU bus. It builds a 5-bit bank number from a sequence of CPU writes. Each write delivers one bit, taken from data bit 0. The writes must land in a fixed register address window, which by default is the range where the top three address bits are `101`, that is $A000–$BFFF. The fifth accepted write commits the whole number at once. A write with data bit 7 set abandons a partial load.

The committed number is treated as a 4 KB CHR bank index. This holds whatever CHR mode the rest of the mapper uses, so the bits taken from it never move. Selected bits of the number drive the upper work-RAM address lines, two RAM chip enables and a flag that marks the battery-backed region. A static variant input picks one of four board wirings:

- a single 8 KB chip;
- two 8 KB chips with complementary enables;
- a 32 KB part with four banks;
- a part whose RAM-related bit is bit 4.

The RAM outputs follow the RAM-window decode input with no register delay.

Top module: `wram_bank_ctrl`

## Requirements
- R1: After reset the count and shift state are empty and the committed number is 0, so RAM bank 0 is selected: in the two-chip variant `ram_ce0` follows `ram_win`, and in the four-bank variant `ram_ahi` is 0.
- R2: Writes with `cpu_d7`=0 shift `cpu_d0` in least significant bit first, and the number commits on the fifth such write. Outputs stay at the old number after writes one to four and show the new number from the clock edge of the fifth write.
- R3: A register write with `cpu_d7`=1 clears the count and partial bits without committing. Five further writes are then needed for a commit.
- R4: Writes whose `cpu_addr[15:13]` is not `101` leave the count, the partial bits and the committed number unchanged.
- R5: With `ram_win`=0, `ram_ce0`, `ram_ce1` and `ram_batt` are all 0 in every variant.
- R6: Variant 0 (single 8 KB, `variant`=2'b00): `ram_ahi`=0, `ram_ce0`=`ram_win`, `ram_ce1`=0, `ram_batt`=`ram_win`, whatever the number holds.
- R7: Variant 1 (two chips, `variant`=2'b01): bit 3 of the number selects the chip. `ram_ce0`=`ram_win`&~bit3 and `ram_ce1`=`ram_win`&bit3. `ram_ahi`=0, and bits 4 and 2 have no effect.
- R8: Variant 1: `ram_batt` is high only while the bit-3 chip (bank 2/3 of the four-bank map) is enabled. Banks 1 and 3 alias banks 0 and 2.
- R9: Variant 2 (32 KB, `variant`=2'b10): `ram_ahi`={bit3,bit2}, `ram_ce0`=`ram_win`, `ram_ce1`=0, `ram_batt`=`ram_win`.
- R10: Variant 3 (`variant`=2'b11): `ram_ahi`={0,bit4}, `ram_ce0`=`ram_win`, `ram_ce1`=0, `ram_batt`=`ram_win`. Bit 3 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_d0 | input | 1 | CPU data bit 0, the serial bit |
| cpu_d7 | input | 1 | CPU data bit 7, load abort |
| cpu_wr | input | 1 | One-cycle write strobe |
| ram_win | input | 1 | Decode of the work-RAM window ($6000–$7FFF) |
| variant | input | 2 | Board wiring select (static) |
| ram_ahi | output | 2 | Work-RAM address bits 14:13 |
| ram_ce0 | output | 1 | First RAM chip enable |
| ram_ce1 | output | 1 | Second RAM chip enable |
| ram_batt | output | 1 | Access targets battery-backed RAM |

## Verification
A write is held across one rising edge. The committed number, and with it every RAM output, changes at the edge of the fifth write. The bench therefore samples at the following falling edge, one edge after the write, and at the same point after writes one to four to confirm nothing has moved yet. Changes to `ram_win` and `variant` reach the outputs combinationally, so those checks sample a settled half cycle later with no edge in between. Expected values come from a bench model of the shift sequence and a per-variant mapping function.

// File: rtl/wram_bank_pkg.sv
package wram_bank_pkg;
   typedef enum logic [1:0] {
      VAR_SINGLE = 2'd0,
      VAR_DUAL   = 2'd1,
      VAR_QUAD   = 2'd2,
      VAR_HIGH   = 2'd3
   } wram_variant_e;

   typedef struct packed {
      logic ce0;
      logic ce1;
      logic batt;
   } ram_en_t;
endpackage

// File: rtl/wram_serial_loader.sv
module wram_serial_loader #(
   parameter int ADDR_W   = 16,
   parameter int REG_BITS = 5,
   parameter int WIN_BITS = 3,
   parameter logic [WIN_BITS-1:0] WIN_CODE = 3'b101
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   addr,
   input  logic                d0,
   input  logic                d7,
   input  logic                wr,
   output logic [REG_BITS-1:0] value
);
   localparam int CNT_W = $clog2(REG_BITS + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(REG_BITS - 1);

   if (REG_BITS < 2)        begin : g_bad_bits $error("REG_BITS must be at least 2"); end
   if (WIN_BITS > ADDR_W)   begin : g_bad_win  $error("WIN_BITS exceeds ADDR_W"); end

   logic                hit;
   logic [CNT_W-1:0]    cnt;
   logic [REG_BITS-1:0] sr;

   assign hit = wr && (addr[ADDR_W-1 -: WIN_BITS] == WIN_CODE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt   <= '0;
         sr    <= '0;
         value <= '0;
      end else if (hit) begin
         if (d7) begin
            cnt <= '0;
            sr  <= '0;
         end else if (cnt == LAST) begin
            value <= {d0, sr[REG_BITS-1:1]};
            sr    <= '0;
            cnt   <= '0;
         end else begin
            sr  <= {d0, sr[REG_BITS-1:1]};
            cnt <= cnt + 1'b1;
         end
      end
   end

   AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LAST); // R2
   AST_COMMIT_FIFTH: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(value) |-> $past(hit && !d7 && cnt == LAST)); // R2
   AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && d7) |=> (cnt == '0 && $stable(value))); // R3
   AST_MISS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |=> ($stable(cnt) && $stable(value))); // R4
endmodule

// File: rtl/wram_router.sv
module wram_router
   import wram_bank_pkg::*;
#(
   parameter int REG_BITS     = 5,
   parameter int AHI_W        = 2,
   parameter int DUAL_SEL_BIT = 3,
   parameter int QUAD_LO_BIT  = 2,
   parameter int HIGH_SEL_BIT = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [REG_BITS-1:0] value,
   input  logic                win,
   input  wram_variant_e       var_sel,
   output logic [AHI_W-1:0]    ahi,
   output ram_en_t             en
);
   if (QUAD_LO_BIT + AHI_W > REG_BITS) begin : g_bad_quad $error("quad field out of range"); end
   if (DUAL_SEL_BIT >= REG_BITS)       begin : g_bad_dual $error("dual select out of range"); end
   if (HIGH_SEL_BIT >= REG_BITS)       begin : g_bad_high $error("high select out of range"); end
   if (AHI_W < 1)                      begin : g_bad_ahi  $error("AHI_W must be positive"); end

   logic [AHI_W-1:0] ahi_quad;
   logic [AHI_W-1:0] ahi_high;
   logic             dual_sel;

   for (genvar i = 0; i < AHI_W; i++) begin : g_quad
      assign ahi_quad[i] = value[QUAD_LO_BIT + i];
   end

   if (AHI_W > 1) begin : g_high_wide
      assign ahi_high = {{(AHI_W-1){1'b0}}, value[HIGH_SEL_BIT]};
   end else begin : g_high_narrow
      assign ahi_high = value[HIGH_SEL_BIT];
   end

   assign dual_sel = value[DUAL_SEL_BIT];

   always_comb begin
      ahi     = '0;
      en.ce0  = win;
      en.ce1  = 1'b0;
      en.batt = win;
      unique case (var_sel)
         VAR_SINGLE: ahi = '0;
         VAR_DUAL: begin
            en.ce0  = win & ~dual_sel;
            en.ce1  = win &  dual_sel;
            en.batt = win &  dual_sel;
         end
         VAR_QUAD: ahi = ahi_quad;
         VAR_HIGH: ahi = ahi_high;
         default:  ahi = '0;
      endcase
   end

   AST_CE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(en.ce0 && en.ce1)); // R7
   AST_CE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      !win |-> (!en.ce0 && !en.ce1 && !en.batt)); // R5
   AST_DUAL_BATT: assert property (@(posedge clk) disable iff (!rst_n)
      (var_sel == VAR_DUAL && en.ce0) |-> !en.batt); // R8
   AST_SINGLE_AHI: assert property (@(posedge clk) disable iff (!rst_n)
      (var_sel == VAR_SINGLE) |-> (ahi == '0)); // R6
endmodule

// File: rtl/wram_bank_ctrl.sv
module wram_bank_ctrl
   import wram_bank_pkg::*;
#(
   parameter int ADDR_W       = 16,
   parameter int REG_BITS     = 5,
   parameter int WIN_BITS     = 3,
   parameter logic [WIN_BITS-1:0] WIN_CODE = 3'b101,
   parameter int AHI_W        = 2,
   parameter int DUAL_SEL_BIT = 3,
   parameter int QUAD_LO_BIT  = 2,
   parameter int HIGH_SEL_BIT = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic              cpu_d0,
   input  logic              cpu_d7,
   input  logic              cpu_wr,
   input  logic              ram_win,
   input  logic [1:0]        variant,
   output logic [AHI_W-1:0]  ram_ahi,
   output logic              ram_ce0,
   output logic              ram_ce1,
   output logic              ram_batt
);
   logic [REG_BITS-1:0] bank_num;
   ram_en_t             en;
   wram_variant_e       var_sel;

   assign var_sel = wram_variant_e'(variant);

   wram_serial_loader #(
      .ADDR_W(ADDR_W), .REG_BITS(REG_BITS), .WIN_BITS(WIN_BITS), .WIN_CODE(WIN_CODE)
   ) i_loader (
      .clk(clk), .rst_n(rst_n), .addr(cpu_addr), .d0(cpu_d0), .d7(cpu_d7),
      .wr(cpu_wr), .value(bank_num)
   );

   wram_router #(
      .REG_BITS(REG_BITS), .AHI_W(AHI_W), .DUAL_SEL_BIT(DUAL_SEL_BIT),
      .QUAD_LO_BIT(QUAD_LO_BIT), .HIGH_SEL_BIT(HIGH_SEL_BIT)
   ) i_router (
      .clk(clk), .rst_n(rst_n), .value(bank_num), .win(ram_win),
      .var_sel(var_sel), .ahi(ram_ahi), .en(en)
   );

   assign ram_ce0  = en.ce0;
   assign ram_ce1  = en.ce1;
   assign ram_batt = en.batt;

   AST_RESET_BANK0: assert property (@(posedge clk)
      !rst_n |=> (bank_num == '0)); // R1
endmodule

// File: tb/test_wram_bank_ctrl.sv
module test_wram_bank_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cpu_addr = '0;
   logic        cpu_d0 = 1'b0, cpu_d7 = 1'b0, cpu_wr = 1'b0, ram_win = 1'b0;
   logic [1:0]  variant = 2'd0;
   logic [1:0]  ram_ahi;
   logic        ram_ce0, ram_ce1, ram_batt;

   int errors = 0, checks = 0;
   bit done = 0;
   logic [4:0] m_sr = '0, m_val = '0;
   int m_cnt = 0;

   always #4 clk = ~clk;

   wram_bank_ctrl i_wram_bank_ctrl (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_d0(cpu_d0), .cpu_d7(cpu_d7),
      .cpu_wr(cpu_wr), .ram_win(ram_win), .variant(variant), .ram_ahi(ram_ahi),
      .ram_ce0(ram_ce0), .ram_ce1(ram_ce1), .ram_batt(ram_batt)
   );

   function automatic logic [4:0] exp_out(input logic [1:0] v, input logic [4:0] n, input logic w);
      case (v)
         2'd0: return {2'b00, w, 1'b0, w};
         2'd1: return {2'b00, w & ~n[3], w & n[3], w & n[3]};
         2'd2: return {n[3:2], w, 1'b0, w};
         default: return {1'b0, n[4], w, 1'b0, w};
      endcase
   endfunction

   task automatic chk(input string tag);
      logic [4:0] e, a;
      e = exp_out(variant, m_val, ram_win);
      a = {ram_ahi, ram_ce0, ram_ce1, ram_batt};
      checks++;
      if (a !== e) begin
         errors++;
         $display("FAIL %s: {ahi,ce0,ce1,batt} actual=%b expected=%b (variant=%0d win=%b)",
                  tag, a, e, variant, ram_win);
      end
   endtask

   task automatic wr(input logic [15:0] a, input logic d0, input logic d7);
      @(negedge clk);
      cpu_addr = a; cpu_d0 = d0; cpu_d7 = d7; cpu_wr = 1'b1;
      @(negedge clk);
      cpu_wr = 1'b0;
      if (a[15:13] == 3'b101) begin
         if (d7) begin m_cnt = 0; m_sr = '0; end
         else if (m_cnt == 4) begin m_val = {d0, m_sr[4:1]}; m_sr = '0; m_cnt = 0; end
         else begin m_sr = {d0, m_sr[4:1]}; m_cnt++; end
      end
   endtask

   task automatic load(input logic [4:0] n);
      for (int i = 0; i < 5; i++) wr(16'hA000 + 16'(i), n[i], 1'b0);
   endtask

   task automatic set_io(input logic [1:0] v, input logic w);
      @(negedge clk); variant = v; ram_win = w; #1;
   endtask

   function automatic string vtag(input logic [1:0] v);
      case (v)
         2'd0: return "R6";
         2'd1: return "R7/R8";
         2'd2: return "R9";
         default: return "R10";
      endcase
   endfunction

   initial begin
      #(200000 * 8);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      set_io(2'd1, 1'b1); chk("R1");
      set_io(2'd2, 1'b1); chk("R1");
      // R2 commit only on fifth write
      set_io(2'd1, 1'b1);
      for (int i = 0; i < 4; i++) begin
         wr(16'hBFFF, (i == 3), 1'b0); chk("R2");
      end
      wr(16'hBFFF, 1'b0, 1'b0); chk("R2");
      chk("R7"); chk("R8");
      // R3 abort mid-load
      wr(16'hA000, 1'b0, 1'b0); wr(16'hA000, 1'b0, 1'b0);
      wr(16'hA000, 1'b0, 1'b1);
      for (int i = 0; i < 3; i++) begin wr(16'hA000, 1'b0, 1'b0); chk("R3"); end
      wr(16'hA000, 1'b0, 1'b0); wr(16'hA000, 1'b1, 1'b0); chk("R3");
      // R4 writes outside the register window
      set_io(2'd2, 1'b1);
      load(5'b00100); chk("R9");
      for (int i = 0; i < 4; i++) wr(16'hA000, 1'b1, 1'b0);
      wr(16'h8000, 1'b0, 1'b0); wr(16'hC000, 1'b0, 1'b1); wr(16'h6000, 1'b0, 1'b0);
      chk("R4");
      wr(16'hA000, 1'b1, 1'b0); chk("R4");
      // R5 window closed
      for (int v = 0; v < 4; v++) begin set_io(2'(v), 1'b0); chk("R5"); end
      // R6/R7/R9/R10 per-variant mapping
      load(5'b10100);
      set_io(2'd0, 1'b1); chk("R6");
      set_io(2'd1, 1'b1); chk("R7");
      set_io(2'd2, 1'b1); chk("R9");
      set_io(2'd3, 1'b1); chk("R10");
      load(5'b01000);
      set_io(2'd3, 1'b1); chk("R10");
      set_io(2'd1, 1'b1); chk("R8");
      // random phase
      for (int k = 0; k < 400; k++) begin
         logic [15:0] a;
         int r;
         r = int'($urandom % 16);
         a = (r < 13) ? (16'hA000 | 16'($urandom % 16'h2000)) : 16'($urandom);
         variant = 2'($urandom % 4);
         ram_win = 1'($urandom % 4 != 0);
         wr(a, 1'($urandom), ($urandom % 12) == 0);
         #1;
         chk(a[15:13] == 3'b101 ? vtag(variant) : "R4");
      end
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule